// File: doc/BRIEF.md
# Wiper and Data Register Controller

This block is the register core of a digitally controlled potentiometer. It holds a volatile wiper value and four retained data registers. A one-hot tap select, decoded from the wiper value, drives the switches of a resistor array. A serial front end decodes each bus transaction into a single-cycle command pulse. The pulse carries an opcode, a register select and a data word, and the front end issues it once the closing stop condition has been seen.

The wiper can be written, read, loaded from any data register, or copied into one. A data-register write, including a copy from the wiper, is modelled as a nonvolatile write cycle. The cycle lasts a parameterised number of clocks, the busy flag stays high for all of it, and the new value is committed only when the cycle ends. While busy, every command is dropped. A low write-protect input blocks both kinds of data-register write but leaves the wiper writable. Reset plays the part of power-up: the data registers keep their contents through it, and the wiper is reloaded from data register 0.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: `tap_sel` always has exactly one bit set, at index `wiper`.
- R2: Wiper value 0 drives `tap_sel[0]` (the low terminal). Wiper value 0x3FF drives `tap_sel[1023]` (the high terminal).
- R3: Opcode 1 (`cmd_op`=3'd1) loads `cmd_data` into the wiper, and the new value is visible after the accepting edge. Opcode 0 returns the wiper on `rd_data`, with `rd_valid` high for one cycle after the accepting edge.
- R4: While `rst_n` is low, the wiper is loaded from data register 0 on every clock. The data registers keep their contents through reset, and they start out as zero.
- R5: Opcode 3 with `wp_n` high starts a write of `cmd_data` into the register chosen by `cmd_sel` (0 to 3). `busy` is high for exactly WR_CYCLES cycles, starting the cycle after acceptance. The register takes the new value when `busy` falls. Opcode 2 reads the selected register back in the same way as R3.
- R6: With `wp_n` low, opcodes 3 and 5 do nothing: `busy` stays low and the data registers are unchanged. Opcode 1 still writes the wiper.
- R7: Opcode 4 copies the selected data register into the wiper, and the new value is visible after the accepting edge.
- R8: Opcode 5 with `wp_n` high writes the current wiper value into the selected data register, using the same timed write cycle as R5.
- R9: Any command accepted while `busy` is high is ignored. This includes a command in the final busy cycle. The wiper does not change and `rd_valid` stays low.
- R10: Opcodes 6 and 7 have no effect on the wiper, on `busy` or on `rd_valid`.
- R11: Asserting reset during a write cycle aborts it. `busy` clears and the target register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; stands for power-up |
| cmd_valid | input | 1 | One-cycle command strobe from the serial front end |
| cmd_op | input | 3 | Opcode: 0 rd wiper, 1 wr wiper, 2 rd reg, 3 wr reg, 4 reg to wiper, 5 wiper to reg |
| cmd_sel | input | 2 | Data register select |
| cmd_data | input | 10 | Write data |
| wp_n | input | 1 | Write protect; low blocks data-register writes |
| rd_data | output | 10 | Read result, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking a read result |
| busy | output | 1 | High during a nonvolatile write cycle |
| wiper | output | 10 | Current wiper value |
| tap_sel | output | 1024 | One-hot tap switch select |

## Verification
Two events can land on the same clock edge. One is the end of a write cycle, which commits the register and drops `busy`. The other is a fresh command. The bench places a wiper write exactly in the last busy cycle and checks that the command is dropped, while the register still commits. It then issues the same command one cycle later, when it must be accepted. The bench also lands reset in the middle of a write cycle and judges the outcome by reading the target register back: it must hold its old value, and the recall must have loaded data register 0 into the wiper.

// File: rtl/wiper_reg_ctrl.sv
module wiper_reg_ctrl #(
  parameter int W = 10,
  parameter int SELW = 2,
  parameter int WR_CYCLES = 625000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [SELW-1:0]     cmd_sel,
  input  logic [W-1:0]        cmd_data,
  input  logic                wp_n,
  output logic [W-1:0]        rd_data,
  output logic                rd_valid,
  output logic                busy,
  output logic [W-1:0]        wiper,
  output logic [(1<<W)-1:0]   tap_sel
);
  localparam int TAPS = 1 << W;
  localparam int NREG = 1 << SELW;
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] OP_RD_WIP = 3'd0, OP_WR_WIP = 3'd1, OP_RD_REG = 3'd2,
                         OP_WR_REG = 3'd3, OP_LOAD = 3'd4, OP_SAVE = 3'd5;

  logic [W-1:0]    dr [NREG] = '{default: '0};
  logic [CW-1:0]   cnt;
  logic [SELW-1:0] psel;
  logic [W-1:0]    pval;

  wire accept = cmd_valid && !busy;

  assign tap_sel = {{(TAPS-1){1'b0}}, 1'b1} << wiper;

  always_ff @(posedge clk) begin
    rd_valid <= 1'b0;
    if (!rst_n) begin
      wiper   <= dr[0];
      busy    <= 1'b0;
      cnt     <= '0;
      rd_data <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy     <= 1'b0;
        dr[psel] <= pval;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (accept) begin
      case (cmd_op)
        OP_RD_WIP: begin rd_data <= wiper; rd_valid <= 1'b1; end
        OP_WR_WIP: wiper <= cmd_data;
        OP_RD_REG: begin rd_data <= dr[cmd_sel]; rd_valid <= 1'b1; end
        OP_LOAD:   wiper <= dr[cmd_sel];
        OP_WR_REG, OP_SAVE:
          if (wp_n) begin
            busy <= 1'b1;
            cnt  <= CW'(WR_CYCLES - 1);
            psel <= cmd_sel;
            pval <= (cmd_op == OP_SAVE) ? wiper : cmd_data;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wiper_reg_ctrl_chk.sv
module wiper_reg_ctrl_chk #(
  parameter int W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic               wp_n,
  input logic               rd_valid,
  input logic               busy,
  input logic [W-1:0]       wiper,
  input logic [(1<<W)-1:0]  tap_sel,
  input logic [W-1:0]       dr0
);
  localparam int TAPS = 1 << W;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  p_low_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper == '0) |-> tap_sel[0]);
  p_high_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper == '1) |-> tap_sel[TAPS-1]);
  p_read_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && (cmd_op == 3'd0 || cmd_op == 3'd2)));
  p_recall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper == dr0));
  p_nv_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && wp_n && (cmd_op == 3'd3 || cmd_op == 3'd5)) |=> busy);
  p_wp_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !wp_n) |=> !busy);
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> ($stable(wiper) && !rd_valid));
  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op[2] && cmd_op[1]) |=> ($stable(wiper) && !busy && !rd_valid));
endmodule

bind wiper_reg_ctrl wiper_reg_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wp_n(wp_n),
  .rd_valid(rd_valid), .busy(busy), .wiper(wiper), .tap_sel(tap_sel), .dr0(dr[0])
);

// File: tb/wiper_reg_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_reg_ctrl_bench;
  localparam int W = 10;
  localparam int NWR = 8;
  localparam int TAPS = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_sel = '0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] rd_data, wiper;
  logic rd_valid, busy;
  logic [TAPS-1:0] tap_sel;
  int checks = 0, errors = 0;
  logic [W-1:0] model [4];

  always #4 clk = ~clk;

  wiper_reg_ctrl #(.W(W), .SELW(2), .WR_CYCLES(NWR)) u_wiper_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .wp_n(wp_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .wiper(wiper), .tap_sel(tap_sel));

  task automatic chk(string req, logic [TAPS-1:0] act, logic [TAPS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, logic [1:0] sel, logic [W-1:0] d);
    cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_nv(string req);
    int n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(req, n, NWR);
  endtask

  task automatic rd_reg(string req, logic [1:0] s, logic [W-1:0] exp);
    cmd(3'd2, s, '0);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 erased recall", wiper, 0);
    chk("R4 busy reset", busy, 0);
    chk("R4 rd_valid reset", rd_valid, 0);

    for (int v = 0; v < TAPS; v++) begin
      cmd(3'd1, 2'd0, W'(v));
      chk("R3 wiper write", wiper, v);
      chk("R1 tap onehot", tap_sel, {{(TAPS-1){1'b0}}, 1'b1} << v);
      if (v % 64 == 5) begin
        cmd(3'd0, 2'd0, '0);
        chk("R3 rd_valid", rd_valid, 1);
        chk("R3 read wiper", rd_data, v);
        @(negedge clk);
        chk("R3 rd_valid pulse", rd_valid, 0);
      end
    end
    cmd(3'd1, 2'd0, 10'h000);
    chk("R2 low terminal", tap_sel[0], 1);
    cmd(3'd1, 2'd0, 10'h3FF);
    chk("R2 high terminal", tap_sel[TAPS-1], 1);

    for (int s = 0; s < 4; s++) begin
      model[s] = W'(10'h155 + s * 77);
      cmd(3'd3, 2'(s), model[s]);
      wait_nv("R5 busy length");
      rd_reg("R5 readback", 2'(s), model[s]);
    end

    for (int s = 3; s >= 0; s--) begin
      cmd(3'd4, 2'(s), '0);
      chk("R7 transfer to wiper", wiper, model[s]);
    end

    wp_n = 1'b0;
    cmd(3'd3, 2'd1, 10'h2F2);
    chk("R6 write blocked busy", busy, 0);
    rd_reg("R6 reg unchanged", 2'd1, model[1]);
    cmd(3'd5, 2'd2, '0);
    chk("R6 save blocked busy", busy, 0);
    rd_reg("R6 reg unchanged save", 2'd2, model[2]);
    cmd(3'd1, 2'd0, 10'h2AA);
    chk("R6 wiper still writable", wiper, 10'h2AA);
    wp_n = 1'b1;

    cmd(3'd1, 2'd0, 10'h0F0);
    cmd(3'd5, 2'd3, '0);
    wait_nv("R8 save busy length");
    model[3] = 10'h0F0;
    rd_reg("R8 save readback", 2'd3, model[3]);

    cmd(3'd3, 2'd0, 10'h3C3);
    model[0] = 10'h3C3;
    cmd(3'd1, 2'd0, 10'h001);
    chk("R9 wiper write ignored", wiper, 10'h0F0);
    cmd(3'd0, 2'd0, '0);
    chk("R9 read ignored", rd_valid, 0);
    cmd(3'd4, 2'd1, '0);
    chk("R9 transfer ignored", wiper, 10'h0F0);
    repeat (4) @(negedge clk);
    chk("R9 still busy last cycle", busy, 1);
    cmd(3'd1, 2'd0, 10'h111);
    chk("R9 last-cycle cmd ignored", wiper, 10'h0F0);
    chk("R5 busy fell", busy, 0);
    cmd(3'd1, 2'd0, 10'h111);
    chk("R9 next cmd accepted", wiper, 10'h111);
    rd_reg("R5 commit at end", 2'd0, model[0]);

    cmd(3'd6, 2'd2, 10'h3FF);
    chk("R10 op6 wiper", wiper, 10'h111);
    chk("R10 op6 busy", busy, 0);
    chk("R10 op6 rd_valid", rd_valid, 0);
    cmd(3'd7, 2'd1, 10'h000);
    chk("R10 op7 wiper", wiper, 10'h111);
    chk("R10 op7 busy", busy, 0);
    chk("R10 op7 rd_valid", rd_valid, 0);

    cmd(3'd3, 2'd1, 10'h00F);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy cleared", busy, 0);
    chk("R4 recall retained DR0", wiper, model[0]);
    rd_reg("R11 aborted write", 2'd1, model[1]);
    for (int s = 0; s < 4; s++) rd_reg("R4 retained", 2'(s), model[s]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule